// File: doc/BRIEF.md
# Outstanding Memory Request Tracker

The tracker sits between a processor-side request port and a cache controller's request queue. Every incoming memory request is classified into a recorded type and a downstream issue type, reduced to its cache-line address, and either accepted into one of two small fully associative tables (read-class or write-class) or refused. A request is refused as full when the tracker already holds its configured maximum, or when the downstream queue cannot take it this cycle. It is refused as aliased when its line is already pending in either table. The status is returned combinationally in the same cycle as the request.

Accepted requests are forwarded on a valid/ready issue interface and stamped with the current cycle count. When the cache side reports a read-class or write-class completion for a line, the matching entry is removed. The block then reports the entry's identifier, recorded type and latency. A round-robin age scan raises a sticky deadlock flag if any pending entry grows too old. A completion naming a line that the selected table does not hold raises a sticky error flag and leaves both tables untouched.

Top module: `rqt_tracker`

## Requirements
- R1: With `req_valid_i` high and the outstanding count at or above `MAX_OUT`, the status is full (2), whatever else holds. A request that passes the count and alias checks but meets `iss_ready_i` low is also full. A full request records nothing.
- R2: Request kinds on `req_kind_i` are 0 load, 1 fetch, 2 store, 3 flush, 4 load-linked, 5 store-conditional, 6 locked read, 7 locked write. A load with `req_stchk_i` high becomes a read-modify-write read. Loads without the flag and fetches are read-class; all others are write-class.
- R3: A request whose line is pending in either the read table or the write table gets status aliased (3) and is not recorded.
- R4: Issue type on `iss_type_o` is 0 load, 1 fetch, 2 store, 3 flush, 4 atomic. Load-linked and store-conditional issue atomic. Locked reads and writes issue store, and so does a store-checked load. Fetch, plain load, store and flush issue as their own type.
- R5: Status is 0 idle, 1 accepted, 2 full, 3 aliased, valid in the request's own cycle. `iss_valid_o` is high exactly when the status is accepted and carries the request address and identifier.
- R6: A completion that hits drives `done_valid_o` in the same cycle with the entry's identifier and recorded type. The recorded type codes are 0 load, 1 fetch, 2 store, 3 flush, 4 load-linked, 5 store-conditional, 6 locked read, 7 locked write, 8 read-modify-write read. `done_latency_o` equals the number of clock edges since acceptance.
- R7: `outstanding_o` always equals the number of occupied entries across both tables. It rises on each accept and falls on each hitting completion.
- R8: `deadlock_o` becomes set and stays set once a pending entry has an age of at least `DL_THRESH` cycles. Detection happens within one scan round of 2*`DEPTH` cycles. It stays clear while no entry has reached that age.
- R9: A completion for a line absent from the table that `cmp_wr_i` selects (1 write, 0 read) sets sticky `cmp_err_o`. It asserts no `done_valid_o` and leaves the count and tables unchanged.
- R10: The line address is the address with its low log2(`LINE_BYTES`) bits cleared. Requests and completions at different byte offsets of one line refer to the same entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_kind_i | input | 3 | Request kind |
| req_stchk_i | input | 1 | Store-check flag for loads |
| req_addr_i | input | AW | Byte address |
| req_id_i | input | IDW | Request identifier |
| req_status_o | output | 2 | Same-cycle status |
| iss_valid_o | output | 1 | Downstream issue valid |
| iss_ready_i | input | 1 | Downstream issue ready |
| iss_type_o | output | 3 | Issue type |
| iss_addr_o | output | AW | Issued address |
| iss_id_o | output | IDW | Issued identifier |
| cmp_valid_i | input | 1 | Completion present |
| cmp_wr_i | input | 1 | Completion targets the write table |
| cmp_addr_i | input | AW | Completed address |
| done_valid_o | output | 1 | Completion retired an entry |
| done_id_o | output | IDW | Identifier of retired entry |
| done_type_o | output | 4 | Recorded type of retired entry |
| done_latency_o | output | TSW | Cycles from accept to completion |
| outstanding_o | output | clog2(MAX_OUT+1) | Entries pending |
| deadlock_o | output | 1 | Sticky age violation |
| cmp_err_o | output | 1 | Sticky unmatched completion |

## Verification
The hardest state to reach is the one where the count limit and a line alias apply at once, and the count limit must win. The bench fills the tracker to exactly `MAX_OUT` with one request of each class, then offers a request to a line that is already pending. A completion and a new request to the same line in one cycle is driven as a separate case. The deadlock path needs an entry left pending past the threshold while the scan pointer cycles. The bench reaches it with a small threshold and a long idle stretch after all other entries are retired.

// File: rtl/rqt_pkg.sv
package rqt_pkg;
  typedef enum logic [2:0] {
    K_LOAD = 3'd0, K_FETCH = 3'd1, K_STORE = 3'd2, K_FLUSH = 3'd3,
    K_LL   = 3'd4, K_SC    = 3'd5, K_LKRD  = 3'd6, K_LKWR  = 3'd7
  } kind_e;

  typedef enum logic [3:0] {
    R_LD = 4'd0, R_IF = 4'd1, R_ST = 4'd2, R_FL = 4'd3, R_LL = 4'd4,
    R_SC = 4'd5, R_LKRD = 4'd6, R_LKWR = 4'd7, R_RMWRD = 4'd8
  } rec_e;

  typedef enum logic [2:0] {
    I_LOAD = 3'd0, I_FETCH = 3'd1, I_STORE = 3'd2, I_FLUSH = 3'd3, I_ATOMIC = 3'd4
  } iss_e;

  typedef enum logic [1:0] {
    S_NONE = 2'd0, S_ACCEPT = 2'd1, S_FULL = 2'd2, S_ALIAS = 2'd3
  } sts_e;
endpackage

// File: rtl/rqt_classify.sv
module rqt_classify
  import rqt_pkg::*;
(
  input  logic [2:0] kind_i,
  input  logic       stchk_i,
  output rec_e       rec_o,
  output iss_e       iss_o,
  output logic       wr_class_o
);
  always_comb begin
    case (kind_e'(kind_i))
      K_LOAD: begin
        rec_o = stchk_i ? R_RMWRD : R_LD;
        iss_o = stchk_i ? I_STORE : I_LOAD;
      end
      K_FETCH: begin rec_o = R_IF;   iss_o = I_FETCH;  end
      K_STORE: begin rec_o = R_ST;   iss_o = I_STORE;  end
      K_FLUSH: begin rec_o = R_FL;   iss_o = I_FLUSH;  end
      K_LL:    begin rec_o = R_LL;   iss_o = I_ATOMIC; end
      K_SC:    begin rec_o = R_SC;   iss_o = I_ATOMIC; end
      K_LKRD:  begin rec_o = R_LKRD; iss_o = I_STORE;  end
      default: begin rec_o = R_LKWR; iss_o = I_STORE;  end
    endcase
    wr_class_o = !(rec_o == R_LD || rec_o == R_IF);
  end
endmodule

// File: rtl/rqt_cam.sv
module rqt_cam
  import rqt_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int TSW   = 16,
  parameter int IDW   = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [AW-1:0]             q_line_i,
  output logic                      q_hit_o,
  input  logic                      ins_i,
  input  logic [AW-1:0]             ins_line_i,
  input  logic [TSW-1:0]            ins_ts_i,
  input  logic [IDW-1:0]            ins_id_i,
  input  rec_e                      ins_rec_i,
  input  logic                      del_i,
  input  logic [AW-1:0]             del_line_i,
  output logic                      del_hit_o,
  output logic [TSW-1:0]            del_ts_o,
  output logic [IDW-1:0]            del_id_o,
  output rec_e                      del_rec_o,
  output logic [DEPTH-1:0]          vld_o,
  output logic [DEPTH-1:0][TSW-1:0] ts_o
);
  logic [DEPTH-1:0] vld_q;
  logic [AW-1:0]    line_q [DEPTH];
  logic [TSW-1:0]   ts_q   [DEPTH];
  logic [IDW-1:0]   id_q   [DEPTH];
  logic [3:0]       rec_q  [DEPTH];
  logic [DEPTH-1:0] qm, dm, free_sel;
  logic [3:0]       rec_acc;
  logic             found;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign qm[g]   = vld_q[g] && (line_q[g] == q_line_i);
    assign dm[g]   = vld_q[g] && (line_q[g] == del_line_i);
    assign ts_o[g] = ts_q[g];
  end

  assign q_hit_o   = |qm;
  assign del_hit_o = |dm;
  assign vld_o     = vld_q;

  // lowest free slot
  always_comb begin
    free_sel = '0;
    found    = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!vld_q[i] && !found) begin
        free_sel[i] = 1'b1;
        found       = 1'b1;
      end
    end
  end

  always_comb begin
    del_ts_o = '0;
    del_id_o = '0;
    rec_acc  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (dm[i]) begin
        del_ts_o = del_ts_o | ts_q[i];
        del_id_o = del_id_o | id_q[i];
        rec_acc  = rec_acc  | rec_q[i];
      end
    end
  end
  assign del_rec_o = rec_e'(rec_acc);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (ins_i && free_sel[i])    vld_q[i] <= 1'b1;
        else if (del_i && dm[i])     vld_q[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (ins_i && free_sel[i]) begin
        line_q[i] <= ins_line_i;
        ts_q[i]   <= ins_ts_i;
        id_q[i]   <= ins_id_i;
        rec_q[i]  <= ins_rec_i;
      end
    end
  end

  // R3: a line is never held twice
  p_unique_line_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(qm));
  // R7: insertion only into a table with room
  p_ins_room_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_i |-> !(&vld_q));
  // R9: a missing completion leaves the table alone
  p_miss_keeps_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (del_i && !del_hit_o && !ins_i) |=> $stable(vld_q));
endmodule

// File: rtl/rqt_wdog.sv
module rqt_wdog #(
  parameter int N      = 16,
  parameter int TSW    = 16,
  parameter int THRESH = 1000
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  active_i,
  input  logic [TSW-1:0]        now_i,
  input  logic [N-1:0]          vld_i,
  input  logic [N-1:0][TSW-1:0] ts_i,
  output logic                  flag_o
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;
  localparam logic [PW-1:0] LAST = PW'(N - 1);

  logic [PW-1:0]  ptr_q;
  logic [TSW-1:0] age;
  logic           flag_q;

  assign age    = now_i - ts_i[ptr_q];
  assign flag_o = flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      flag_q <= 1'b0;
    end else if (active_i) begin
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
      if (vld_i[ptr_q] && age >= TSW'(THRESH)) flag_q <= 1'b1;
    end
  end

  // R8: deadlock flag is sticky
  p_dl_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q |=> flag_q);
endmodule

// File: rtl/rqt_tracker.sv
module rqt_tracker
  import rqt_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 64,
  parameter int DEPTH      = 8,
  parameter int MAX_OUT    = 8,
  parameter int IDW        = 4,
  parameter int TSW        = 16,
  parameter int DL_THRESH  = 1000,
  localparam int CW        = $clog2(MAX_OUT + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_valid_i,
  input  logic [2:0]     req_kind_i,
  input  logic           req_stchk_i,
  input  logic [AW-1:0]  req_addr_i,
  input  logic [IDW-1:0] req_id_i,
  output logic [1:0]     req_status_o,
  output logic           iss_valid_o,
  input  logic           iss_ready_i,
  output logic [2:0]     iss_type_o,
  output logic [AW-1:0]  iss_addr_o,
  output logic [IDW-1:0] iss_id_o,
  input  logic           cmp_valid_i,
  input  logic           cmp_wr_i,
  input  logic [AW-1:0]  cmp_addr_i,
  output logic           done_valid_o,
  output logic [IDW-1:0] done_id_o,
  output logic [3:0]     done_type_o,
  output logic [TSW-1:0] done_latency_o,
  output logic [CW-1:0]  outstanding_o,
  output logic           deadlock_o,
  output logic           cmp_err_o
);
  localparam int OFFW = $clog2(LINE_BYTES);
  localparam logic [AW-1:0] LINE_MASK = ~AW'((1 << OFFW) - 1);
  localparam int NE = 2 * DEPTH;

  rec_e           rec;
  iss_e           iss;
  logic           wr_class;
  logic [AW-1:0]  req_line, cmp_line;
  logic           rd_q_hit, wr_q_hit, rd_d_hit, wr_d_hit;
  logic [TSW-1:0] rd_d_ts, wr_d_ts;
  logic [IDW-1:0] rd_d_id, wr_d_id;
  rec_e           rd_d_rec, wr_d_rec;
  logic [DEPTH-1:0]          rd_vld, wr_vld;
  logic [DEPTH-1:0][TSW-1:0] rd_ts, wr_ts;
  logic [CW-1:0]  cnt_q;
  logic [TSW-1:0] now_q;
  logic           err_q;
  sts_e           sts;
  logic           acc, d_hit;

  rqt_classify u_cls (
    .kind_i(req_kind_i), .stchk_i(req_stchk_i),
    .rec_o(rec), .iss_o(iss), .wr_class_o(wr_class)
  );

  assign req_line = req_addr_i & LINE_MASK;
  assign cmp_line = cmp_addr_i & LINE_MASK;

  // count limit first, then alias, then downstream back-pressure
  always_comb begin
    if (!req_valid_i)                        sts = S_NONE;
    else if (int'(cnt_q) >= MAX_OUT)         sts = S_FULL;
    else if (rd_q_hit || wr_q_hit)           sts = S_ALIAS;
    else if (!iss_ready_i)                   sts = S_FULL;
    else                                     sts = S_ACCEPT;
  end

  assign acc          = (sts == S_ACCEPT);
  assign req_status_o = sts;
  assign iss_valid_o  = acc;
  assign iss_type_o   = iss;
  assign iss_addr_o   = req_addr_i;
  assign iss_id_o     = req_id_i;

  rqt_cam #(.DEPTH(DEPTH), .AW(AW), .TSW(TSW), .IDW(IDW)) u_rd (
    .clk_i, .rst_ni,
    .q_line_i(req_line), .q_hit_o(rd_q_hit),
    .ins_i(acc && !wr_class), .ins_line_i(req_line), .ins_ts_i(now_q),
    .ins_id_i(req_id_i), .ins_rec_i(rec),
    .del_i(cmp_valid_i && !cmp_wr_i), .del_line_i(cmp_line),
    .del_hit_o(rd_d_hit), .del_ts_o(rd_d_ts), .del_id_o(rd_d_id), .del_rec_o(rd_d_rec),
    .vld_o(rd_vld), .ts_o(rd_ts)
  );

  rqt_cam #(.DEPTH(DEPTH), .AW(AW), .TSW(TSW), .IDW(IDW)) u_wr (
    .clk_i, .rst_ni,
    .q_line_i(req_line), .q_hit_o(wr_q_hit),
    .ins_i(acc && wr_class), .ins_line_i(req_line), .ins_ts_i(now_q),
    .ins_id_i(req_id_i), .ins_rec_i(rec),
    .del_i(cmp_valid_i && cmp_wr_i), .del_line_i(cmp_line),
    .del_hit_o(wr_d_hit), .del_ts_o(wr_d_ts), .del_id_o(wr_d_id), .del_rec_o(wr_d_rec),
    .vld_o(wr_vld), .ts_o(wr_ts)
  );

  assign d_hit          = cmp_wr_i ? wr_d_hit : rd_d_hit;
  assign done_valid_o   = cmp_valid_i && d_hit;
  assign done_id_o      = cmp_wr_i ? wr_d_id : rd_d_id;
  assign done_type_o    = cmp_wr_i ? wr_d_rec : rd_d_rec;
  assign done_latency_o = now_q - (cmp_wr_i ? wr_d_ts : rd_d_ts);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      now_q <= '0;
      err_q <= 1'b0;
    end else begin
      now_q <= now_q + 1'b1;
      cnt_q <= cnt_q + CW'(acc) - CW'(done_valid_o);
      if (cmp_valid_i && !d_hit) err_q <= 1'b1;
    end
  end

  assign outstanding_o = cnt_q;
  assign cmp_err_o     = err_q;

  rqt_wdog #(.N(NE), .TSW(TSW), .THRESH(DL_THRESH)) u_wd (
    .clk_i, .rst_ni,
    .active_i(cnt_q != '0), .now_i(now_q),
    .vld_i({wr_vld, rd_vld}), .ts_i({wr_ts, rd_ts}),
    .flag_o(deadlock_o)
  );

  // R7: count tracks table occupancy
  p_count_sum_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) == ($countones(rd_vld) + $countones(wr_vld)));
  // R1: nothing issues at the limit
  p_full_blocks_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(cnt_q) >= MAX_OUT) |-> !iss_valid_o);
  // R5: issue only with a ready sink and a live request
  p_issue_hs_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_valid_o |-> (iss_ready_i && req_valid_i));
  // R6: a lone retirement lowers the count by one
  p_retire_dec_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_valid_o && !iss_valid_o) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R9: unmatched completion flag is sticky
  p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
endmodule

// File: tb/rqt_tracker_tb_top.sv
`timescale 1ns/100ps
module rqt_tracker_tb_top;
  localparam int AW = 32, IDW = 4, TSW = 16, DEPTH = 8, MAX_OUT = 6, THR = 60;
  localparam int CW = $clog2(MAX_OUT + 1);
  localparam int NE = 2 * DEPTH;
  localparam logic [31:0] MASK = 32'hFFFF_FFC0;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic           req_valid, req_stchk, iss_ready, cmp_valid, cmp_wr;
  logic [2:0]     req_kind;
  logic [AW-1:0]  req_addr, cmp_addr, iss_addr;
  logic [IDW-1:0] req_id, iss_id, done_id;
  logic [1:0]     status;
  logic           iss_valid, done_valid, deadlock, cmp_err;
  logic [2:0]     iss_type;
  logic [3:0]     done_type;
  logic [TSW-1:0] done_lat;
  logic [CW-1:0]  outstanding;

  rqt_tracker #(.AW(AW), .LINE_BYTES(64), .DEPTH(DEPTH), .MAX_OUT(MAX_OUT),
                .IDW(IDW), .TSW(TSW), .DL_THRESH(THR)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_kind_i(req_kind), .req_stchk_i(req_stchk),
    .req_addr_i(req_addr), .req_id_i(req_id), .req_status_o(status),
    .iss_valid_o(iss_valid), .iss_ready_i(iss_ready), .iss_type_o(iss_type),
    .iss_addr_o(iss_addr), .iss_id_o(iss_id),
    .cmp_valid_i(cmp_valid), .cmp_wr_i(cmp_wr), .cmp_addr_i(cmp_addr),
    .done_valid_o(done_valid), .done_id_o(done_id), .done_type_o(done_type),
    .done_latency_o(done_lat), .outstanding_o(outstanding),
    .deadlock_o(deadlock), .cmp_err_o(cmp_err)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  always @(posedge clk) if (rst_n) cyc++;

  // reference model
  int rd_ts[int unsigned], rd_id[int unsigned], rd_ty[int unsigned];
  int wr_ts[int unsigned], wr_id[int unsigned], wr_ty[int unsigned];
  int m_cnt = 0;
  bit m_err = 0, dl_may = 0, dl_must = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // R2: recorded type code
  function automatic int exp_rec(input int k, input bit sc);
    if (k == 0) return sc ? 8 : 0;
    return k;
  endfunction
  // R4: issue type code
  function automatic int exp_iss(input int k, input bit sc);
    case (k)
      0: return sc ? 2 : 0;
      1: return 1;
      2: return 2;
      3: return 3;
      4, 5: return 4;
      default: return 2;
    endcase
  endfunction

  task automatic step(input bit rv, input int k, input bit sc, input logic [31:0] a,
                      input int id, input bit rdy, input bit cv, input bit cw,
                      input logic [31:0] ca);
    int unsigned rl, cl;
    int est, lat, ts_v;
    bit acc, hit, wcls;
    req_valid = rv; req_kind = 3'(k); req_stchk = sc; req_addr = a; req_id = 4'(id);
    iss_ready = rdy; cmp_valid = cv; cmp_wr = cw; cmp_addr = ca;
    #1;
    rl = a & MASK; cl = ca & MASK;
    wcls = !((k == 0 && !sc) || k == 1);
    if (!rv) est = 0;
    else if (m_cnt >= MAX_OUT) est = 2;
    else if (rd_ts.exists(rl) || wr_ts.exists(rl)) est = 3;
    else if (!rdy) est = 2;
    else est = 1;
    acc = (est == 1);
    chk("R1_R3_R5_R10 status", int'(status), est);
    chk("R5 iss_valid", int'(iss_valid), int'(acc));
    if (acc) begin
      chk("R4 iss_type", int'(iss_type), exp_iss(k, sc));
      chk("R5 iss_addr", int'(iss_addr), int'(a));
      chk("R5 iss_id", int'(iss_id), id);
    end
    hit = cv && (cw ? wr_ts.exists(cl) : rd_ts.exists(cl));
    chk("R6_R9 done_valid", int'(done_valid), int'(hit));
    if (hit) begin
      ts_v = cw ? wr_ts[cl] : rd_ts[cl];
      lat = cyc - ts_v;
      chk("R6 latency", int'(done_lat), lat);
      chk("R6 id", int'(done_id), cw ? wr_id[cl] : rd_id[cl]);
      chk("R2_R6 type", int'(done_type), cw ? wr_ty[cl] : rd_ty[cl]);
    end
    chk("R7 outstanding", int'(outstanding), m_cnt);
    chk("R9 cmp_err", int'(cmp_err), int'(m_err));
    foreach (rd_ts[kk]) begin
      if (cyc - rd_ts[kk] >= THR) dl_may = 1;
      if (cyc - rd_ts[kk] >= THR + NE + 3) dl_must = 1;
    end
    foreach (wr_ts[kk]) begin
      if (cyc - wr_ts[kk] >= THR) dl_may = 1;
      if (cyc - wr_ts[kk] >= THR + NE + 3) dl_must = 1;
    end
    if (dl_must) chk("R8 deadlock set", int'(deadlock), 1);
    else if (!dl_may) chk("R8 deadlock clear", int'(deadlock), 0);
    ts_v = cyc;
    @(posedge clk);
    if (acc) begin
      if (wcls) begin wr_ts[rl] = ts_v; wr_id[rl] = id; wr_ty[rl] = exp_rec(k, sc); end
      else      begin rd_ts[rl] = ts_v; rd_id[rl] = id; rd_ty[rl] = exp_rec(k, sc); end
      m_cnt++;
    end
    if (hit) begin
      if (cw) begin wr_ts.delete(cl); wr_id.delete(cl); wr_ty.delete(cl); end
      else    begin rd_ts.delete(cl); rd_id.delete(cl); rd_ty.delete(cl); end
      m_cnt--;
    end
    if (cv && !hit) m_err = 1;
    @(negedge clk);
  endtask

  task automatic req(input int k, input bit sc, input logic [31:0] a, input int id, input bit rdy);
    step(1'b1, k, sc, a, id, rdy, 1'b0, 1'b0, 32'h0);
  endtask
  task automatic cmp(input bit cw, input logic [31:0] ca);
    step(1'b0, 0, 1'b0, 32'h0, 0, 1'b1, 1'b1, cw, ca);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, 1'b0, 32'h0, 0, 1'b1, 1'b0, 1'b0, 32'h0);
  endtask

  initial begin
    req_valid = 0; req_kind = 0; req_stchk = 0; req_addr = 0; req_id = 0;
    iss_ready = 1; cmp_valid = 0; cmp_wr = 0; cmp_addr = 0;
    #12;
    // reset state
    chk("R7 reset outstanding", int'(outstanding), 0);
    chk("R8 reset deadlock", int'(deadlock), 0);
    chk("R9 reset err", int'(cmp_err), 0);
    @(negedge clk); rst_n = 1'b1; @(negedge clk);
    idle(2);
    // R2 R4: one of several kinds, distinct lines
    req(0, 0, 32'h1000, 1, 1);
    req(1, 0, 32'h1040, 2, 1);
    req(0, 1, 32'h1080, 3, 1);
    req(2, 0, 32'h10C0, 4, 1);
    req(4, 0, 32'h1100, 5, 1);
    req(5, 0, 32'h1140, 6, 1);
    // R1: at limit, full even on an aliased line
    req(0, 0, 32'h1000, 7, 1);
    req(3, 0, 32'h5000, 7, 1);
    cmp(1'b0, 32'h1010);            // R10 offset within the line
    // R3 with R10 offsets
    req(2, 0, 32'h1044, 8, 1);      // write vs pending read
    req(0, 0, 32'h10C8, 8, 1);      // read vs pending write
    req(1, 0, 32'h1050, 8, 1);      // read vs pending read
    req(7, 0, 32'h1108, 8, 1);      // write vs pending write
    // R1: back-pressure
    req(3, 0, 32'h2000, 9, 0);
    req(3, 0, 32'h2000, 9, 1);
    // R9: unmatched completions
    cmp(1'b1, 32'h1000);
    cmp(1'b1, 32'h1040);
    idle(3);
    cmp(1'b0, 32'h1040);
    cmp(1'b1, 32'h1080);
    idle(2);
    cmp(1'b1, 32'h10C0);
    // request and completion in one cycle
    step(1'b1, 6, 1'b0, 32'h3000, 10, 1'b1, 1'b1, 1'b1, 32'h1100);
    step(1'b1, 7, 1'b0, 32'h3040, 11, 1'b1, 1'b1, 1'b1, 32'h1140);
    // same line completing while re-requested: still aliased
    step(1'b1, 0, 1'b0, 32'h3000, 12, 1'b1, 1'b1, 1'b1, 32'h3000);
    cmp(1'b1, 32'h2000);
    cmp(1'b1, 32'h3040);
    idle(1);
    // R8: one entry left aging past the threshold
    req(0, 0, 32'h4000, 13, 1);
    idle(THR + NE + 10);
    chk("R8 deadlock final", int'(deadlock), 1);
    cmp(1'b0, 32'h4000);
    idle(2);
    chk("R8 deadlock stays", int'(deadlock), 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule